// File: doc/BRIEF.md
# Framed Serial Odd-Parity Detector

The block takes a serial bit stream, one bit per rising clock edge, and splits it into back-to-back frames of a fixed length (three bits by default). For each frame it reports whether the frame holds an odd number of ones. A frame with no ones counts as even. Frame boundaries come from a position counter that a synchronous reset aligns. The first bit sampled after reset is released is the first bit of a frame. There is no other frame synchronisation.

A parameter selects when the result appears. In the same-cycle option, the result is formed combinationally from the running parity and the frame's last bit, and is valid while that last bit is on the input. In the registered option, the result comes from flops only. It is valid during the cycle after the last bit is sampled, which is the cycle that carries the first bit of the next frame. In both options a one-cycle strobe marks the result, and the result line is held low whenever the strobe is low.

Top module: `parity3_detector`

## Requirements
- R1: `din` is sampled on every rising edge of `clk`. Frames are `FRAME_BITS` bits long (default 3) and follow each other with no gap. The first bit sampled after `rst` is released is bit 0 of a frame.
- R2: The frame result is 1 exactly when the frame contains an odd number of ones. Any 3-bit pattern is accepted, including the values 0 to 4 sent as binary.
- R3: A frame with zero ones (pattern 000) yields a result of 0 while the strobe is high.
- R4: With `MOORE_MODE`=0, `valid_o` is high during the cycle in which the last bit of a frame is present on `din`. `odd_o` is formed in that same cycle from the stored parity and the current `din`.
- R5: With `MOORE_MODE`=1, `valid_o` and `odd_o` come straight from flops. They are high during the cycle after the last bit is sampled, which is the cycle that carries bit 0 of the next frame. A change on `din` within that cycle does not alter them.
- R6: `valid_o` pulses for exactly one cycle per completed frame and is never high in two consecutive cycles.
- R7: `odd_o` is 0 whenever `valid_o` is 0.
- R8: Each frame's result depends only on its own bits. A preceding odd frame does not affect the next frame.
- R9: While `rst` is high at a rising edge, the position counter and the parity state clear, and both outputs read 0 in the cycle after that edge. A reset in the middle of a frame discards the partial frame, and realigns the stream so that the next sampled bit is bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data, one bit per clock |
| odd_o | output | 1 | Frame holds an odd number of ones; 0 when not valid |
| valid_o | output | 1 | One-cycle strobe marking a frame result |

## Verification
A wrong position count shows at the ports as a strobe that lands on the wrong bit of a frame. The first frame after reset already exposes this, because the bench checks the strobe on every bit. A wrong parity state shows as a flipped result on the next completed frame. Feeding an odd frame followed by an all-zero frame exposes a parity that is not cleared at the frame start within one frame. A reset in the middle of a frame, followed by an odd frame, exposes a counter or parity that survives reset in the same frame.

// File: rtl/parity3_detector.sv
module parity3_detector #(
  parameter int FRAME_BITS = 3,
  parameter bit MOORE_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic odd_o,
  output logic valid_o
);
  localparam int POS_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic [POS_W-1:0] pos;
  logic             acc;

  wire at_last   = (pos == LAST_POS);
  wire at_first  = (pos == '0);
  wire frame_par = (at_first ? 1'b0 : acc) ^ din;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      acc <= 1'b0;
    end else begin
      pos <= at_last ? '0 : pos + 1'b1;
      acc <= frame_par;
    end
  end

  generate
    if (MOORE_MODE) begin : g_moore
      logic res_v, res_odd;
      always_ff @(posedge clk) begin
        if (rst) begin
          res_v   <= 1'b0;
          res_odd <= 1'b0;
        end else begin
          res_v   <= at_last;
          res_odd <= at_last & frame_par;
        end
      end
      assign valid_o = res_v;
      assign odd_o   = res_odd;
    end else begin : g_mealy
      assign valid_o = !rst && at_last;
      assign odd_o   = valid_o && frame_par;
    end
  endgenerate
endmodule

// File: rtl/parity3_detector_chk.sv
module parity3_detector_chk #(
  parameter int FRAME_BITS = 3,
  parameter bit MOORE_MODE = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic odd_o,
  input logic valid_o
);
  localparam int PH_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
  localparam logic [PH_W-1:0] PH_END = PH_W'(FRAME_BITS - 1);

  logic [PH_W-1:0] ph;
  logic            seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= '0;
      seen <= 1'b0;
    end else begin
      ph   <= (ph == PH_END) ? '0 : ph + 1'b1;
      if (ph == PH_END) seen <= 1'b1;
    end
  end

  generate
    if (MOORE_MODE) begin : g_moore_chk
      // R5
      strobe_align_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o == (ph == '0 && seen));
    end else begin : g_mealy_chk
      // R4
      strobe_align_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o == (ph == PH_END));
    end
  endgenerate

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R7
  odd_gated_chk: assert property (@(posedge clk) disable iff (rst)
    odd_o |-> valid_o);

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!valid_o && !odd_o));
endmodule

bind parity3_detector parity3_detector_chk #(
  .FRAME_BITS(FRAME_BITS),
  .MOORE_MODE(MOORE_MODE)
) u_chk (
  .clk(clk),
  .rst(rst),
  .odd_o(odd_o),
  .valid_o(valid_o)
);

// File: tb/tb_parity3_detector.sv
module tb_parity3_detector;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // bit 3 = expected result, bits 2:0 = frame, sent MSB first
  localparam logic [3:0] VECS [NVEC] = '{
    4'b0000, 4'b1001, 4'b1010, 4'b0011, 4'b1100,
    4'b0101, 4'b0110, 4'b1111, 4'b0000, 4'b1100
  };

  logic clk = 1'b0, rst = 1'b1, din = 1'b0;
  logic me_v, me_o, mo_v, mo_o;
  int checks = 0, fails = 0;
  bit have_prev = 1'b0;
  logic prev_odd = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  parity3_detector #(.FRAME_BITS(3), .MOORE_MODE(1'b0)) dut (
    .clk(clk), .rst(rst), .din(din), .odd_o(me_o), .valid_o(me_v));
  parity3_detector #(.FRAME_BITS(3), .MOORE_MODE(1'b1)) dut_moore (
    .clk(clk), .rst(rst), .din(din), .odd_o(mo_o), .valid_o(mo_v));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // called at a falling edge; leaves at the next falling edge
  task automatic send_bit(input logic b, input int idx, input logic exp_odd, input string req);
    din = b;
    #1;
    chk(req, "same-cycle valid", me_v, idx == 2);
    chk(req, "same-cycle odd", me_o, (idx == 2) ? exp_odd : 1'b0);
    chk(req, "registered valid", mo_v, idx == 0 && have_prev);
    chk(req, "registered odd", mo_o, (idx == 0 && have_prev) ? prev_odd : 1'b0);
    if (idx == 0 && have_prev) begin
      din = ~b;
      #1;
      chk("R5", "registered odd stable vs din", mo_o, prev_odd);
      din = b;
    end
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [2:0] v, input logic exp_odd, input string req);
    for (int i = 0; i < 3; i++) send_bit(v[2-i], i, exp_odd, req);
    have_prev = 1'b1;
    prev_odd  = exp_odd;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    din = 1'b1;
    @(negedge clk);
    #1;
    chk("R9", "valid in reset", me_v, 1'b0);
    chk("R9", "odd in reset", me_o, 1'b0);
    chk("R9", "reg valid in reset", mo_v, 1'b0);
    chk("R9", "reg odd in reset", mo_o, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    have_prev = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R2 R4 R5 R6 R7: table walk through every 3-bit pattern
    for (int k = 0; k < NVEC; k++)
      send_frame(VECS[k][2:0], VECS[k][3], "R2");
    // R3: all-zero frame
    send_frame(3'b000, 1'b0, "R3");
    // R8: odd frame then even frame, parity must not carry
    send_frame(3'b111, 1'b1, "R8");
    send_frame(3'b000, 1'b0, "R8");
    send_frame(3'b011, 1'b0, "R8");
    // R9: reset in mid-frame realigns and clears parity
    send_bit(1'b1, 0, 1'b0, "R9");
    send_bit(1'b1, 1, 1'b0, "R9");
    do_reset();
    // R1: first bit after release is bit 0
    send_frame(3'b100, 1'b1, "R1");
    send_frame(3'b001, 1'b1, "R9");
    send_frame(3'b000, 1'b0, "R6");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule